// File: doc/BRIEF.md
# LED Output Protection and Stagger Gate

This block sits between the per-channel PWM enables of an LED sink driver and its output stages. It staggers when channels turn on so that the channels do not all switch in the same instant. Channel c belongs to phase c mod 4. Phase 0 passes straight through. Phases 1, 2 and 3 are held back by one, two and three ticks of a delay strobe. A tick is one system-clock cycle in which `stagger_tick_i` is high.

Two protection conditions act on top of the staggered enables, and either one turns every output off. The first is a thermal condition, built from two comparator bits that are synchronized into the clock domain and kept apart by hysteresis. The flag trips on the upper comparator and releases on the lower one. The flag is always reported, but it blanks the outputs only while shutdown is enabled.

The second condition is a timeout on the grayscale clock. A free-running system-clock counter is restarted by every synchronized rising edge of the grayscale clock. When the counter runs out, the outputs are blanked. The timeout stays latched until two things have happened: the grayscale clock has produced an edge again, and a new-data strobe has arrived. At that point the block releases the outputs and asks the PWM counters to restart with a one-cycle pulse.

The delay lines keep shifting throughout any shutdown, so the data path stays live.

Top module: `led_guard_gate`

## Requirements
- R1: A channel whose index mod 4 is 0 drives `gated_en_o` from `pwm_en_i` in the same cycle, with no register in between, whenever no protection condition is active.
- R2: A channel in phase g (g = index mod 4, 1..3) outputs the `pwm_en_i` value that was captured at the g-th most recent tick. The delay state changes only in cycles where `stagger_tick_i` is 1.
- R3: `hot_trip_i` and `cool_rel_i` each pass through two flip-flops before they are used. The thermal flag sets one cycle after the synchronized trip bit is 1. It clears one cycle after the synchronized release bit is 1 while the trip bit is 0. In every other cycle it holds its value, and trip wins if both bits are high.
- R4: `therm_flag_o` is reported even when `cfg_tsd_en_i` is 0, and with shutdown disabled the flag has no effect on `gated_en_o`.
- R5: While `cfg_tsd_en_i` is 1 and the thermal flag is 1, every bit of `gated_en_o` is 0.
- R6: During a thermal shutdown the delay lines keep capturing on ticks. In the first cycle after the flag clears, every output again shows its live delayed value.
- R7: With `cfg_wd_off_i` = 0, TIMEOUT_CYCLES consecutive cycles without a detected rising edge of the grayscale clock latch a timeout. From the next cycle on, every output is 0.
- R8: A latched timeout is left in place by a `new_data_i` pulse that arrives before any grayscale-clock edge has been seen since the timeout. It clears at the first `new_data_i` pulse after such an edge.
- R9: When a timeout clears, `cnt_reset_o` is 1 for exactly one cycle, in the cycle after the clearing strobe. It is 0 at all other times.
- R10: While `cfg_wd_off_i` is 1 no timeout can latch, and any latched timeout is dropped one cycle later.
- R11: After reset the thermal flag, `cnt_reset_o`, the timeout and all delay state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_en_i | input | NUM_CH | Per-channel PWM enables from the comparators |
| stagger_tick_i | input | 1 | Delay strobe; one tick per cycle in which it is high |
| hot_trip_i | input | 1 | Asynchronous comparator: temperature above the trip level |
| cool_rel_i | input | 1 | Asynchronous comparator: temperature below the release level |
| gsclk_i | input | 1 | Asynchronous grayscale clock, watched for rising edges |
| new_data_i | input | 1 | One-cycle strobe: new serial data has been loaded |
| cfg_tsd_en_i | input | 1 | 1 = the thermal flag blanks the outputs |
| cfg_wd_off_i | input | 1 | 1 = grayscale-clock timeout disabled |
| gated_en_o | output | NUM_CH | Staggered and protected enables to the output stages |
| therm_flag_o | output | 1 | Thermal flag with hysteresis |
| cnt_reset_o | output | 1 | One-cycle request to restart the PWM counters |

## Verification
The assertions assume that `new_data_i` and `stagger_tick_i` are synchronous to `clk_i`. They also assume the grayscale clock is slow enough, compared with the system clock, that each of its levels lasts at least two system cycles, so the synchronizer never merges two edges. The stimulus drives every input at the falling clock edge and toggles the grayscale clock once every four system cycles. It stops that clock only in the stretches that deliberately exercise the timeout, and there it runs the bench with TIMEOUT_CYCLES set to 64.

// File: rtl/led_guard_pkg.sv
package led_guard_pkg;

  // Phase of a channel: which stagger delay it receives.
  function automatic int phase_of(input int ch, input int phases);
    return ch % phases;
  endfunction

  // Blanking decision from the two protection conditions.
  function automatic logic blank_needed(input logic flag, input logic tsd_en,
                                        input logic timed_out);
    return (flag & tsd_en) | timed_out;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sync_2ff.sv
module sync_2ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/stagger_line.sv
module stagger_line #(
  parameter int NUM_CH     = 16,
  parameter int NUM_PHASES = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 tick_i,
  input  logic [NUM_CH-1:0]                    en_i,
  output logic [NUM_PHASES-1:0][NUM_CH-1:0]    taps_o
);
  // tap 0 is the live input; tap k is the value captured k ticks ago
  assign taps_o[0] = en_i;

  genvar k;
  generate
    for (k = 1; k < NUM_PHASES; k++) begin : g_stage
      logic [NUM_CH-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else if (tick_i) stage_q <= taps_o[k-1];
      end
      assign taps_o[k] = stage_q;
    end
  endgenerate
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_trip_i,
  input  logic cool_rel_i,
  output logic hot_sync_o,
  output logic cool_sync_o,
  output logic flag_o
);
  logic flag_q;

  sync_2ff u_hot_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(hot_trip_i), .q_o(hot_sync_o)
  );
  sync_2ff u_cool_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cool_rel_i), .q_o(cool_sync_o)
  );

  // trip wins over release; between the two levels the flag holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (hot_sync_o)  flag_q <= 1'b1;
    else if (cool_sync_o) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gsclk_watchdog.sv
module gsclk_watchdog #(
  parameter int TIMEOUT_CYCLES = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gsclk_i,
  input  logic new_data_i,
  input  logic disable_i,
  output logic gs_edge_o,
  output logic timed_out_o,
  output logic restart_o
);
  localparam int CW = led_guard_pkg::cnt_width(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LAST_IDLE = CW'(TIMEOUT_CYCLES - 1);
  localparam logic [CW-1:0] SAT_IDLE  = CW'(TIMEOUT_CYCLES);

  logic          gs_sync;
  logic          gs_prev_q;
  logic [CW-1:0] idle_q;
  logic          timed_out_q;
  logic          seen_q;
  logic          restart_q;
  logic          release_now;

  sync_2ff u_gs_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(gsclk_i), .q_o(gs_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gs_prev_q <= 1'b0;
    else         gs_prev_q <= gs_sync;
  end

  assign gs_edge_o   = gs_sync & ~gs_prev_q;
  assign release_now = timed_out_q & seen_q & new_data_i;

  // idle counter, saturating at the timeout value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idle_q <= '0;
    else if (disable_i)           idle_q <= '0;
    else if (gs_edge_o)           idle_q <= '0;
    else if (idle_q != SAT_IDLE)  idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timed_out_q <= 1'b0;
      seen_q      <= 1'b0;
      restart_q   <= 1'b0;
    end else if (disable_i) begin
      timed_out_q <= 1'b0;
      seen_q      <= 1'b0;
      restart_q   <= 1'b0;
    end else begin
      restart_q <= release_now;
      if (release_now) begin
        timed_out_q <= 1'b0;
        seen_q      <= 1'b0;
      end else if (timed_out_q) begin
        if (gs_edge_o) seen_q <= 1'b1;
      end else if (!gs_edge_o && idle_q == LAST_IDLE) begin
        timed_out_q <= 1'b1;
      end
    end
  end

  assign timed_out_o = timed_out_q;
  assign restart_o   = restart_q;
endmodule

// File: rtl/led_guard_gate.sv
module led_guard_gate #(
  parameter int NUM_CH         = 16,
  parameter int NUM_PHASES     = 4,
  parameter int TIMEOUT_CYCLES = 125_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pwm_en_i,
  input  logic              stagger_tick_i,
  input  logic              hot_trip_i,
  input  logic              cool_rel_i,
  input  logic              gsclk_i,
  input  logic              new_data_i,
  input  logic              cfg_tsd_en_i,
  input  logic              cfg_wd_off_i,
  output logic [NUM_CH-1:0] gated_en_o,
  output logic              therm_flag_o,
  output logic              cnt_reset_o
);
  localparam int LINE_BITS = (NUM_PHASES - 1) * NUM_CH;

  logic [NUM_PHASES-1:0][NUM_CH-1:0] taps;
  logic [LINE_BITS-1:0]              line_state;
  logic                              hot_sync;
  logic                              cool_sync;
  logic                              gs_edge;
  logic                              wd_timed_out;
  logic                              force_off;

  stagger_line #(.NUM_CH(NUM_CH), .NUM_PHASES(NUM_PHASES)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (stagger_tick_i),
    .en_i   (pwm_en_i),
    .taps_o (taps)
  );

  thermal_guard u_therm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hot_trip_i  (hot_trip_i),
    .cool_rel_i  (cool_rel_i),
    .hot_sync_o  (hot_sync),
    .cool_sync_o (cool_sync),
    .flag_o      (therm_flag_o)
  );

  gsclk_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gsclk_i     (gsclk_i),
    .new_data_i  (new_data_i),
    .disable_i   (cfg_wd_off_i),
    .gs_edge_o   (gs_edge),
    .timed_out_o (wd_timed_out),
    .restart_o   (cnt_reset_o)
  );

  assign line_state = taps[NUM_PHASES-1:1];
  assign force_off  = led_guard_pkg::blank_needed(therm_flag_o, cfg_tsd_en_i, wd_timed_out);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int PH = led_guard_pkg::phase_of(c, NUM_PHASES);
      assign gated_en_o[c] = taps[PH][c] & ~force_off;
    end
  endgenerate
endmodule

// File: rtl/led_guard_gate_chk.sv
module led_guard_gate_chk #(
  parameter int NUM_CH     = 16,
  parameter int NUM_PHASES = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             stagger_tick_i,
  input logic                             cfg_tsd_en_i,
  input logic                             cfg_wd_off_i,
  input logic [NUM_CH-1:0]                gated_en_o,
  input logic                             therm_flag_o,
  input logic                             cnt_reset_o,
  input logic                             hot_sync,
  input logic                             cool_sync,
  input logic                             wd_timed_out,
  input logic [(NUM_PHASES-1)*NUM_CH-1:0] line_state
);
  p_line_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stagger_tick_i |=> $stable(line_state));

  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_flag_o && !cool_sync) |=> therm_flag_o);

  p_flag_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(therm_flag_o) |-> $past(hot_sync));

  p_shutdown_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_flag_o && cfg_tsd_en_i) |-> (gated_en_o == '0));

  p_timeout_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_timed_out |-> (gated_en_o == '0));

  p_restart_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_reset_o |=> !cnt_reset_o);

  p_restart_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_reset_o |-> ($past(wd_timed_out) && !wd_timed_out));

  p_wd_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wd_off_i |=> !wd_timed_out);
endmodule

bind led_guard_gate led_guard_gate_chk #(.NUM_CH(NUM_CH), .NUM_PHASES(NUM_PHASES)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stagger_tick_i (stagger_tick_i),
  .cfg_tsd_en_i   (cfg_tsd_en_i),
  .cfg_wd_off_i   (cfg_wd_off_i),
  .gated_en_o     (gated_en_o),
  .therm_flag_o   (therm_flag_o),
  .cnt_reset_o    (cnt_reset_o),
  .hot_sync       (hot_sync),
  .cool_sync      (cool_sync),
  .wd_timed_out   (wd_timed_out),
  .line_state     (line_state)
);

// File: tb/led_guard_gate_tb_top.sv
module led_guard_gate_tb_top;
  localparam int NCH = 16;
  localparam int TMO = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pwm = '0;
  logic           tick = 1'b0;
  logic           hot = 1'b0;
  logic           cool = 1'b0;
  logic           gs = 1'b0;
  logic           nd = 1'b0;
  logic           tsd_en = 1'b0;
  logic           wd_off = 1'b0;
  wire  [NCH-1:0] gated;
  wire            tflag;
  wire            crst;

  int compared = 0;
  int mismatched = 0;
  string phase_tag = "R11";
  bit gs_run = 1'b1;
  int gs_div = 0;
  int cyc = 0;

  // behavioural reference state
  bit hot_pipe[2] = '{0, 0};
  bit cool_pipe[2] = '{0, 0};
  bit gs_pipe[3] = '{0, 0, 0};
  bit m_flag = 0;
  bit m_tmo = 0;
  bit m_seen = 0;
  bit m_pulse = 0;
  int m_idle = 0;
  logic [NCH-1:0] tick_hist[$] = '{16'h0, 16'h0, 16'h0};

  always #4 clk = ~clk;

  led_guard_gate #(.NUM_CH(NCH), .NUM_PHASES(4), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk_i (clk), .rst_ni(rst_n), .pwm_en_i(pwm), .stagger_tick_i(tick),
    .hot_trip_i(hot), .cool_rel_i(cool), .gsclk_i(gs), .new_data_i(nd),
    .cfg_tsd_en_i(tsd_en), .cfg_wd_off_i(wd_off),
    .gated_en_o(gated), .therm_flag_o(tflag), .cnt_reset_o(crst)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      hot_pipe = '{0, 0}; cool_pipe = '{0, 0}; gs_pipe = '{0, 0, 0};
      m_flag = 0; m_tmo = 0; m_seen = 0; m_pulse = 0; m_idle = 0;
      tick_hist = '{16'h0, 16'h0, 16'h0};
    end else begin
      bit rise;
      bit clear;
      rise = gs_pipe[1] && !gs_pipe[2];
      if (hot_pipe[1]) m_flag = 1;
      else if (cool_pipe[1]) m_flag = 0;
      hot_pipe[1] = hot_pipe[0]; hot_pipe[0] = hot;
      cool_pipe[1] = cool_pipe[0]; cool_pipe[0] = cool;
      if (wd_off) begin
        m_tmo = 0; m_seen = 0; m_pulse = 0; m_idle = 0;
      end else begin
        clear = m_tmo && m_seen && nd;
        m_pulse = clear;
        if (rise) m_idle = 0; else m_idle++;
        if (clear) begin m_tmo = 0; m_seen = 0; end
        else if (m_tmo) begin if (rise) m_seen = 1; end
        else if (m_idle == TMO) m_tmo = 1;
      end
      gs_pipe[2] = gs_pipe[1]; gs_pipe[1] = gs_pipe[0]; gs_pipe[0] = gs;
      if (tick) begin
        tick_hist.push_front(pwm);
        void'(tick_hist.pop_back());
      end
    end
  end

  function automatic logic [NCH-1:0] expected_gated();
    logic [NCH-1:0] v;
    bit blank;
    blank = (m_flag && tsd_en) || m_tmo;
    for (int c = 0; c < NCH; c++) begin
      int g;
      g = c % 4;
      v[c] = (g == 0) ? pwm[c] : tick_hist[g-1][c];
    end
    return blank ? '0 : v;
  endfunction

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    check({phase_tag, " gated"}, gated, expected_gated());
    check("R3 flag", {15'b0, tflag}, {15'b0, m_flag});
    check("R9 restart", {15'b0, crst}, {15'b0, m_pulse});
    pwm  = NCH'($urandom);
    tick = (cyc % 3 == 0);
    if (gs_run) begin
      gs_div++;
      if (gs_div == 4) begin gs_div = 0; gs = ~gs; end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 flag", {15'b0, tflag}, 16'h0);
    check("R11 restart", {15'b0, crst}, 16'h0);
    check("R11 gated", gated, 16'h0);
    rst_n = 1'b1;
    phase_tag = "R1/R2";
    run(60);
    // thermal flag with shutdown disabled: reported, no blanking
    phase_tag = "R4";
    hot = 1'b1; run(6); hot = 1'b0; run(5);
    check("R4 flag held", {15'b0, tflag}, 16'h1);
    cool = 1'b1; run(5); cool = 1'b0; run(4);
    // both comparators high: trip wins
    phase_tag = "R3";
    hot = 1'b1; cool = 1'b1; run(5); hot = 1'b0; run(5); cool = 1'b0; run(3);
    // shutdown enabled
    phase_tag = "R5";
    tsd_en = 1'b1;
    hot = 1'b1; run(4); hot = 1'b0; run(20);
    check("R5 blanked", gated, 16'h0);
    phase_tag = "R6";
    cool = 1'b1; run(8); cool = 1'b0; run(10);
    tsd_en = 1'b0;
    // grayscale clock stops
    phase_tag = "R7";
    gs_run = 1'b0; run(TMO + 16);
    check("R7 blanked", gated, 16'h0);
    phase_tag = "R8";
    nd = 1'b1; run(1); nd = 1'b0; run(8);
    check("R8 still blanked", gated, 16'h0);
    gs_run = 1'b1; run(14);
    phase_tag = "R9";
    nd = 1'b1; run(1); nd = 1'b0; run(10);
    // timeout disabled
    phase_tag = "R10";
    wd_off = 1'b1; gs_run = 1'b0; run(TMO + 40);
    gs_run = 1'b1; run(12); wd_off = 1'b0; run(20);
    // timeout latched, then dropped by the disable bit
    gs_run = 1'b0; run(TMO + 10);
    wd_off = 1'b1; run(4); gs_run = 1'b1; run(12); wd_off = 1'b0;
    phase_tag = "R1/R2";
    run(30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule